// File: doc/BRIEF.md
# Serial Receive FIFO with Threshold Flag

This block sits behind a serial receiver and stores the bytes it assembles until software or a DMA engine takes them. Bytes come in on a valid/ready push port and leave on a valid/ready pop port, oldest first. The number of stored bytes is always visible on an 8-bit count output.

A 2-bit threshold select picks a fill level. When the registered occupancy reaches that level, a sticky ready flag sets. The flag also drives the receive request line, which a DMA engine can use as its trigger. Software clears the flag by first reading it as 1 and then writing 0. If the FIFO is still at or above the threshold when it is cleared, the flag sets again straight away.

Push back-pressure: `in_ready` is low while the FIFO holds the full depth. The receiver cannot stall, so a push offered while `in_ready` is low is dropped and reported by a one-cycle overrun pulse. Pop back-pressure: `out_valid` is low while the FIFO is empty. A pop offered then is ignored, and `out_data` keeps the last byte that was popped. A synchronous FIFO-clear input empties the store.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset, `count` is 0, `out_valid`, `rdy_flag`, `rx_req` and `ovr_pulse` are 0, and `out_data` is 0.
- R2: Bytes leave in the order they were accepted. `out_data` shows the oldest stored byte while `out_valid` is 1. `in_ready` is 0 exactly when 16 bytes are stored.
- R3: A push offered while 16 bytes are stored is dropped. `count` stays 16, and `ovr_pulse` is 1 for exactly the one cycle after that edge.
- R4: A pop offered while the FIFO is empty leaves `count` unchanged, and `out_data` keeps showing the last byte that was popped.
- R5: A push and a pop accepted on the same edge both take effect, and `count` is unchanged.
- R6: `count` gives the occupancy, zero-extended to 8 bits. It updates on the edge that accepts a push or a pop.
- R7: `trig_sel` encodes the threshold as 0 = 1 byte, 1 = 4 bytes, 2 = 8 bytes, 3 = 14 bytes. `rdy_flag` sets on the edge after the one at which `count` first becomes equal to or greater than the threshold.
- R8: Once set, `rdy_flag` stays 1 until an accepted clear, even if `count` falls below the threshold or the FIFO is cleared.
- R9: A clear is accepted only when a write with `flag_wr_val` = 0 follows a `flag_rd` strobe seen while `rdy_flag` was 1. Any flag write, accepted or not, disarms the clear. Writes with `flag_wr_val` = 1 are ignored, and a write of 0 that is not armed is ignored.
- R10: If an accepted clear happens while `count` is at or above the threshold, `rdy_flag` reads 0 for one cycle and 1 in the cycle after.
- R11: `rx_req` always equals `rdy_flag`.
- R12: `fifo_clr` makes `count` 0 and `out_valid` 0 on the next edge. It takes priority over a push or a pop on that same edge, and it leaves `rdy_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Push request from the receiver |
| in_ready | output | 1 | FIFO can accept a byte |
| in_data | input | 8 | Byte to push |
| out_valid | output | 1 | FIFO holds at least one byte |
| out_ready | input | 1 | Pop request |
| out_data | output | 8 | Oldest byte, or the last popped byte when empty |
| fifo_clr | input | 1 | Synchronous FIFO clear |
| trig_sel | input | 2 | Threshold select |
| count | output | 8 | Occupancy |
| rdy_flag | output | 1 | Sticky threshold flag |
| flag_rd | input | 1 | Strobe: software read the flag |
| flag_wr_en | input | 1 | Strobe: software writes the flag |
| flag_wr_val | input | 1 | Value written to the flag |
| rx_req | output | 1 | Interrupt/DMA request |
| ovr_pulse | output | 1 | One-cycle pulse for a dropped push |

## Verification
The bench fills the FIFO to the brim and then pushes once more. A design that overwrote a slot would later pop a wrong byte, and one that wrapped its count would show 0. Popping an empty FIFO checks that the last byte is held and the count does not underflow. Pushing and popping on the same edge would expose a count that drifts.

Each threshold setting is walked one byte at a time. A design that decoded the select wrongly, or compared with the wrong inequality, would raise the flag early or late.

The clear handshake is exercised with a write of 1, with an unarmed write of 0, and with a clear while the FIFO is still above the threshold. A design that cleared too easily, or kept the flag low after an ineffective clear, would fail these checks.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
  typedef enum logic [1:0] {
    THR_A = 2'd0,
    THR_B = 2'd1,
    THR_C = 2'd2,
    THR_D = 2'd3
  } thr_sel_e;
endpackage

// File: rtl/rtf_store.sv
module rtf_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         do_push,
  input  logic         do_pop,
  input  logic         empty,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [W-1:0]  last_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      last_q <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop) begin
        rd_ptr <= bump(rd_ptr);
        last_q <= mem[rd_ptr];
      end
    end
  end

  assign rd_data = empty ? last_q : mem[rd_ptr];
endmodule

// File: rtl/rtf_level.sv
module rtf_level
  import rtf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_A = 1,
  parameter int LVL_B = 4,
  parameter int LVL_C = 8,
  parameter int LVL_D = 14,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          do_push,
  input  logic          do_pop,
  input  logic [1:0]    thr_sel,
  output logic [CW-1:0] occ,
  output logic          hit
);
  logic [CW-1:0] occ_q;
  logic [CW-1:0] thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 occ_q <= '0;
    else if (clr)               occ_q <= '0;
    else if (do_push && !do_pop) occ_q <= occ_q + 1'b1;
    else if (do_pop && !do_push) occ_q <= occ_q - 1'b1;
  end

  always_comb begin
    unique case (thr_sel_e'(thr_sel))
      THR_A:   thr = CW'(LVL_A);
      THR_B:   thr = CW'(LVL_B);
      THR_C:   thr = CW'(LVL_C);
      default: thr = CW'(LVL_D);
    endcase
  end

  assign occ = occ_q;
  assign hit = (occ_q >= thr);
endmodule

// File: rtl/rtf_flag.sv
module rtf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic rd_stb,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag
);
  logic flag_q, armed_q, clr_ok;

  assign clr_ok = wr_en && !wr_val && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q <= clr_ok ? 1'b0 : (flag_q | hit);
      if (wr_en)                armed_q <= 1'b0;
      else if (rd_stb && flag_q) armed_q <= 1'b1;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int DEPTH   = 16,
  parameter int W       = 8,
  parameter int COUNT_W = 8,
  parameter int LVL_A   = 1,
  parameter int LVL_B   = 4,
  parameter int LVL_C   = 8,
  parameter int LVL_D   = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [W-1:0]       in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [W-1:0]       out_data,
  input  logic               fifo_clr,
  input  logic [1:0]         trig_sel,
  output logic [COUNT_W-1:0] count,
  output logic               rdy_flag,
  input  logic               flag_rd,
  input  logic               flag_wr_en,
  input  logic               flag_wr_val,
  output logic               rx_req,
  output logic               ovr_pulse
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [CW-1:0] occ;
  logic hit, full, empty, do_push, do_pop, ovr_q;

  assign full    = (occ == FULL_C);
  assign empty   = (occ == '0);
  assign do_push = in_valid && !full && !fifo_clr;
  assign do_pop  = out_ready && !empty && !fifo_clr;

  rtf_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .do_push(do_push), .do_pop(do_pop), .empty(empty),
    .wr_data(in_data), .rd_data(out_data)
  );

  rtf_level #(.DEPTH(DEPTH), .LVL_A(LVL_A), .LVL_B(LVL_B),
              .LVL_C(LVL_C), .LVL_D(LVL_D)) u_level (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .do_push(do_push), .do_pop(do_pop), .thr_sel(trig_sel),
    .occ(occ), .hit(hit)
  );

  rtf_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .rd_stb(flag_rd),
    .wr_en(flag_wr_en), .wr_val(flag_wr_val), .flag(rdy_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= in_valid && full && !fifo_clr;
  end

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign count     = COUNT_W'(occ);
  assign rx_req    = rdy_flag;
  assign ovr_pulse = ovr_q;
endmodule

// File: rtl/rtf_checker.sv
module rtf_checker #(
  parameter int DEPTH   = 16,
  parameter int W       = 8,
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [W-1:0]       out_data,
  input logic               fifo_clr,
  input logic [COUNT_W-1:0] count,
  input logic               rdy_flag,
  input logic               flag_wr_en,
  input logic               flag_wr_val,
  input logic               rx_req,
  input logic               ovr_pulse
);
  assert_full_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == COUNT_W'(DEPTH)) |-> !in_ready);

  assert_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !fifo_clr) |=> (ovr_pulse && $stable(count)));

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready && !in_valid && !fifo_clr) |=> ($stable(count) && $stable(out_data)));

  assert_both_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready && !fifo_clr) |=> $stable(count));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= COUNT_W'(DEPTH));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_flag && !(flag_wr_en && !flag_wr_val)) |=> rdy_flag);

  assert_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req == rdy_flag);

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (count == '0 && !out_valid));
endmodule

bind rx_trig_fifo rtf_checker #(.DEPTH(DEPTH), .W(W), .COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .fifo_clr(fifo_clr), .count(count), .rdy_flag(rdy_flag),
  .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val),
  .rx_req(rx_req), .ovr_pulse(ovr_pulse)
);

// File: tb/sim_rx_trig_fifo.sv
`timescale 1ns/1ps
module sim_rx_trig_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, out_ready = 0, fifo_clr = 0;
  logic flag_rd = 0, flag_wr_en = 0, flag_wr_val = 0;
  logic [7:0] in_data = '0;
  logic [1:0] trig_sel = '0;
  logic in_ready, out_valid, rdy_flag, rx_req, ovr_pulse;
  logic [7:0] out_data, count;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  rx_trig_fifo u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .fifo_clr(fifo_clr), .trig_sel(trig_sel),
    .count(count), .rdy_flag(rdy_flag), .flag_rd(flag_rd),
    .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val),
    .rx_req(rx_req), .ovr_pulse(ovr_pulse)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    in_valid = 1; in_data = d; tick(); in_valid = 0;
  endtask

  task automatic pop_expect(string req, input logic [7:0] d);
    chk(req, out_data, d);
    out_ready = 1; tick(); out_ready = 0;
  endtask

  task automatic flush();
    fifo_clr = 1; tick(); fifo_clr = 0;
  endtask

  task automatic arm_and_write(input logic v);
    flag_rd = 1; tick(); flag_rd = 0;
    flag_wr_en = 1; flag_wr_val = v; tick(); flag_wr_en = 0; flag_wr_val = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 flag", rdy_flag, 0);
    chk("R11 req", rx_req, 0);
    chk("R1 ovr", ovr_pulse, 0);
    chk("R1 data", out_data, 0);
  endtask

  task automatic t_order();
    trig_sel = 2'd3;
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    chk("R6 count", count, 5);
    for (int i = 0; i < 5; i++) pop_expect("R2 order", 8'h10 + 8'(i));
    chk("R6 count drained", count, 0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push(8'hA0 + 8'(i));
    chk("R2 in_ready full", in_ready, 0);
    chk("R6 count full", count, 16);
    in_valid = 1; in_data = 8'h55; tick(); in_valid = 0;
    chk("R3 ovr pulse", ovr_pulse, 1);
    chk("R3 count held", count, 16);
    tick();
    chk("R3 ovr one cycle", ovr_pulse, 0);
    for (int i = 0; i < 16; i++) pop_expect("R3 data kept", 8'hA0 + 8'(i));
  endtask

  task automatic t_empty_pop();
    chk("R4 last data", out_data, 8'hAF);
    out_ready = 1; tick(); out_ready = 0;
    chk("R4 count", count, 0);
    chk("R4 data held", out_data, 8'hAF);
  endtask

  task automatic t_both();
    push(8'h01); push(8'h02); push(8'h03);
    in_valid = 1; in_data = 8'h04; out_ready = 1; tick();
    in_valid = 0; out_ready = 0;
    chk("R5 count", count, 3);
    pop_expect("R5 order", 8'h02);
    pop_expect("R5 order", 8'h03);
    pop_expect("R5 order", 8'h04);
  endtask

  task automatic t_thresholds();
    int lv[4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      flush();
      if (rdy_flag) arm_and_write(1'b0);
      chk("R9 flag cleared", rdy_flag, 0);
      trig_sel = 2'(s);
      for (int i = 0; i < lv[s] - 1; i++) push(8'(i));
      tick();
      chk("R7 below thr", rdy_flag, 0);
      push(8'hEE);
      chk("R7 lag", rdy_flag, 0);
      tick();
      chk("R7 set", rdy_flag, 1);
      chk("R11 req", rx_req, 1);
    end
  endtask

  task automatic t_sticky_and_clr();
    in_valid = 1; in_data = 8'h77; fifo_clr = 1; tick();
    in_valid = 0; fifo_clr = 0;
    chk("R12 count", count, 0);
    chk("R12 valid", out_valid, 0);
    chk("R8 flag kept", rdy_flag, 1);
    tick();
    chk("R8 still set", rdy_flag, 1);
  endtask

  task automatic t_clear_rules();
    arm_and_write(1'b1);
    tick();
    chk("R9 write1 ignored", rdy_flag, 1);
    flag_wr_en = 1; flag_wr_val = 0; tick(); flag_wr_en = 0;
    tick();
    chk("R9 unarmed ignored", rdy_flag, 1);
    arm_and_write(1'b0);
    chk("R9 clear", rdy_flag, 0);
    tick();
    chk("R9 stays clear", rdy_flag, 0);
  endtask

  task automatic t_reassert();
    trig_sel = 2'd1;
    for (int i = 0; i < 5; i++) push(8'(i));
    tick();
    chk("R7 set", rdy_flag, 1);
    arm_and_write(1'b0);
    chk("R10 low one cycle", rdy_flag, 0);
    tick();
    chk("R10 reasserted", rdy_flag, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1;
    tick();
    t_order();
    t_overrun();
    t_empty_pop();
    t_both();
    t_thresholds();
    t_sticky_and_clr();
    t_clear_rules();
    t_reassert();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule